// File: doc/BRIEF.md
# Reservation-Based Load/Store-Conditional Unit

This unit carries out the two halves of an optimistic atomic sequence for a 32- or 64-bit integer core. A reserving load reads memory, returns the value sign-extended to the register width and remembers the address it read. A conditional store writes memory only while that address is still remembered, and reports a status code back to the destination register. One reservation is held at a time. Addresses pass straight through to memory, so no translation is done.

Each operation is taken on a ready/valid request. It finishes in one of two ways: a one-cycle completion pulse that writes the register, or a completion pulse that reports an exception. Memory is reached through a single-beat request that is held until a response arrives. The response can signal an error. A synchronous clear input models the loss of the reservation when another agent writes the line.

Top module: `lrsc_unit`

## Requirements
- R1: After reset, `resv_valid`, `mem_req_valid` and `done_valid` are low and `req_ready` is high.
- R2: `req_size` codes are 0 byte, 1 half, 2 word, 3 double. A byte access is always aligned. A half needs address bit 0 clear, a word needs bits 1:0 clear, and a double needs bits 2:0 clear.
- R3: A misaligned reserving load completes in the cycle after it is accepted. It reports exception code 4 with the address, writes no register and issues no memory request, and it leaves the reservation unchanged.
- R4: A misaligned conditional store completes in the same way with exception code 6.
- R5: An access wider than XLEN/8 bytes (a double when XLEN is 32) completes with exception code 2 and issues no memory request.
- R6: An aligned reserving load issues a read of the given address and size. When the response arrives, it writes the low size×8 bits of the data, sign-extended to XLEN, and records the address as the reservation.
- R7: A conditional store whose address does not equal a valid reservation issues no memory request. It writes 1 to the register and leaves the reservation invalid.
- R8: A conditional store that hits the reservation writes the low size×8 bits of the store data, with upper bits zero. On an error-free response it writes 0 to the register, and the reservation is invalid afterwards.
- R9: An error response reports code 5 for a load or code 7 for a store, with the address, and writes no register. The failed load sets no reservation, and the failed store drops the reservation.
- R10: For a load, memory acquire equals aq and release equals aq AND rl. For a store, acquire equals aq AND rl and release equals rl.
- R11: `resv_clear` invalidates the reservation at the next edge. It takes priority over a load that completes in the same cycle.
- R12: The memory request, with its address and data, stays asserted and stable until `mem_rsp_valid`.
- R13: `req_ready` is low while a memory access is outstanding. `done_valid` is a single-cycle pulse in the cycle after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit idle, request accepted |
| req_is_sc | input | 1 | 1 conditional store, 0 reserving load |
| req_addr | input | XLEN | Access address |
| req_size | input | 2 | Width code |
| req_wdata | input | XLEN | Store source value |
| req_aq | input | 1 | Acquire ordering bit |
| req_rl | input | 1 | Release ordering bit |
| resv_clear | input | 1 | External reservation invalidate |
| resv_valid | output | 1 | Reservation held |
| mem_req_valid | output | 1 | Memory request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | XLEN | Memory address |
| mem_req_size | output | 2 | Width code |
| mem_req_wdata | output | XLEN | Write data, zero above width |
| mem_req_acquire | output | 1 | Acquire semantics |
| mem_req_release | output | 1 | Release semantics |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_error | input | 1 | Response carries an error |
| mem_rsp_rdata | input | XLEN | Read data |
| done_valid | output | 1 | Completion pulse |
| done_rd_we | output | 1 | Destination register write |
| done_rd_data | output | XLEN | Destination register value |
| done_exc_valid | output | 1 | Exception raised |
| done_exc_code | output | 4 | Exception cause code |
| done_exc_addr | output | XLEN | Faulting address |

## Verification
The hardest case to reach is an external clear that lands in the same cycle as the memory response that would set the reservation. The stimulus holds a load's request open and returns the response with `resv_clear` pulsed on that same edge. A later store to the same address must then fail without touching memory. A second instance built with a 32-bit width covers the over-wide access.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } lrsc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } lrsc_state_e;

    localparam int EXC_W = 4;
    localparam logic [EXC_W-1:0] EXC_ILLEGAL  = 4'd2;
    localparam logic [EXC_W-1:0] EXC_LD_MISAL = 4'd4;
    localparam logic [EXC_W-1:0] EXC_LD_FAULT = 4'd5;
    localparam logic [EXC_W-1:0] EXC_ST_MISAL = 4'd6;
    localparam logic [EXC_W-1:0] EXC_ST_FAULT = 4'd7;
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] addr,
    input  logic [1:0]      size,
    output logic            legal,
    output logic            aligned
);
    localparam int MAX_BYTES = XLEN / 8;

    generate
        if (MAX_BYTES >= 8) begin : g_wide
            assign legal = 1'b1;
        end else begin : g_narrow
            assign legal = (size != SZ_DBL);
        end
    endgenerate

    always_comb begin
        unique case (size)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = ~addr[0];
            SZ_WORD: aligned = (addr[1:0] == 2'b00);
            default: aligned = (addr[2:0] == 3'b000);
        endcase
    end
endmodule

// File: rtl/lrsc_data_fmt.sv
module lrsc_data_fmt
    import lrsc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]      ld_size,
    input  logic [XLEN-1:0] ld_raw,
    output logic [XLEN-1:0] ld_ext,
    input  logic [1:0]      st_size,
    input  logic [XLEN-1:0] st_raw,
    output logic [XLEN-1:0] st_trunc
);
    always_comb begin
        unique case (ld_size)
            SZ_BYTE: ld_ext = XLEN'($signed(ld_raw[7:0]));
            SZ_HALF: ld_ext = XLEN'($signed(ld_raw[15:0]));
            SZ_WORD: ld_ext = XLEN'($signed(ld_raw[31:0]));
            default: ld_ext = ld_raw;
        endcase
    end

    always_comb begin
        unique case (st_size)
            SZ_BYTE: st_trunc = XLEN'(st_raw[7:0]);
            SZ_HALF: st_trunc = XLEN'(st_raw[15:0]);
            SZ_WORD: st_trunc = XLEN'(st_raw[31:0]);
            default: st_trunc = st_raw;
        endcase
    end
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [AW-1:0] set_addr,
    input  logic          drop,
    input  logic          ext_clear,
    input  logic [AW-1:0] probe_addr,
    output logic          valid,
    output logic          hit
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
    } resv_t;

    resv_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ext_clear || drop) begin
            r_d.vld = 1'b0;
        end else if (set) begin
            r_d.vld  = 1'b1;
            r_d.addr = set_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign valid = r_q.vld;
    assign hit   = r_q.vld && (r_q.addr == probe_addr);

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clear |=> !valid); // R11
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_is_sc,
    input  logic [XLEN-1:0]  req_addr,
    input  logic [1:0]       req_size,
    input  logic [XLEN-1:0]  req_wdata,
    input  logic             req_aq,
    input  logic             req_rl,
    input  logic             resv_clear,
    output logic             resv_valid,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [1:0]       mem_req_size,
    output logic [XLEN-1:0]  mem_req_wdata,
    output logic             mem_req_acquire,
    output logic             mem_req_release,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_error,
    input  logic [XLEN-1:0]  mem_rsp_rdata,
    output logic             done_valid,
    output logic             done_rd_we,
    output logic [XLEN-1:0]  done_rd_data,
    output logic             done_exc_valid,
    output logic [EXC_W-1:0] done_exc_code,
    output logic [XLEN-1:0]  done_exc_addr
);
    typedef struct packed {
        lrsc_state_e      st;
        logic             is_sc;
        logic [XLEN-1:0]  addr;
        logic [1:0]       size;
        logic [XLEN-1:0]  wdata;
        logic             aq;
        logic             rl;
        logic             dn_valid;
        logic             dn_sc;
        logic             dn_we;
        logic [XLEN-1:0]  dn_data;
        logic             dn_exc;
        logic [EXC_W-1:0] dn_code;
        logic [XLEN-1:0]  dn_addr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic            dec_legal, dec_aligned;
    logic [XLEN-1:0] ld_ext, st_trunc;
    logic            resv_hit, resv_set, resv_drop;

    lrsc_decode #(.XLEN(XLEN)) u_decode (
        .addr    (req_addr),
        .size    (req_size),
        .legal   (dec_legal),
        .aligned (dec_aligned)
    );

    lrsc_data_fmt #(.XLEN(XLEN)) u_fmt (
        .ld_size  (c_q.size),
        .ld_raw   (mem_rsp_rdata),
        .ld_ext   (ld_ext),
        .st_size  (req_size),
        .st_raw   (req_wdata),
        .st_trunc (st_trunc)
    );

    lrsc_resv_reg #(.AW(XLEN)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (resv_set),
        .set_addr   (c_q.addr),
        .drop       (resv_drop),
        .ext_clear  (resv_clear),
        .probe_addr (req_addr),
        .valid      (resv_valid),
        .hit        (resv_hit)
    );

    always_comb begin
        c_d          = c_q;
        c_d.dn_valid = 1'b0;
        c_d.dn_sc    = 1'b0;
        c_d.dn_we    = 1'b0;
        c_d.dn_data  = '0;
        c_d.dn_exc   = 1'b0;
        c_d.dn_code  = '0;
        c_d.dn_addr  = '0;
        resv_set     = 1'b0;
        resv_drop    = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.is_sc = req_is_sc;
                    c_d.addr  = req_addr;
                    c_d.size  = req_size;
                    c_d.wdata = st_trunc;
                    c_d.aq    = req_aq;
                    c_d.rl    = req_rl;
                    if (!dec_legal) begin
                        c_d.dn_valid = 1'b1;
                        c_d.dn_sc    = req_is_sc;
                        c_d.dn_exc   = 1'b1;
                        c_d.dn_code  = EXC_ILLEGAL;
                        c_d.dn_addr  = req_addr;
                    end else if (!dec_aligned) begin
                        c_d.dn_valid = 1'b1;
                        c_d.dn_sc    = req_is_sc;
                        c_d.dn_exc   = 1'b1;
                        c_d.dn_code  = req_is_sc ? EXC_ST_MISAL : EXC_LD_MISAL;
                        c_d.dn_addr  = req_addr;
                    end else if (req_is_sc && !resv_hit) begin
                        c_d.dn_valid = 1'b1;
                        c_d.dn_sc    = 1'b1;
                        c_d.dn_we    = 1'b1;
                        c_d.dn_data  = XLEN'(1);
                        resv_drop    = 1'b1;
                    end else begin
                        c_d.st = ST_MEM;
                    end
                end
            end
            default: begin
                if (mem_rsp_valid) begin
                    c_d.st       = ST_IDLE;
                    c_d.dn_valid = 1'b1;
                    c_d.dn_sc    = c_q.is_sc;
                    if (c_q.is_sc) begin
                        resv_drop = 1'b1;
                    end
                    if (mem_rsp_error) begin
                        c_d.dn_exc  = 1'b1;
                        c_d.dn_code = c_q.is_sc ? EXC_ST_FAULT : EXC_LD_FAULT;
                        c_d.dn_addr = c_q.addr;
                    end else if (c_q.is_sc) begin
                        c_d.dn_we   = 1'b1;
                        c_d.dn_data = '0;
                    end else begin
                        c_d.dn_we   = 1'b1;
                        c_d.dn_data = ld_ext;
                        resv_set    = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready       = (c_q.st == ST_IDLE);
    assign mem_req_valid   = (c_q.st == ST_MEM);
    assign mem_req_write   = c_q.is_sc;
    assign mem_req_addr    = c_q.addr;
    assign mem_req_size    = c_q.size;
    assign mem_req_wdata   = c_q.wdata;
    assign mem_req_acquire = c_q.is_sc ? (c_q.aq & c_q.rl) : c_q.aq;
    assign mem_req_release = c_q.is_sc ? c_q.rl : (c_q.aq & c_q.rl);

    assign done_valid     = c_q.dn_valid;
    assign done_rd_we     = c_q.dn_we;
    assign done_rd_data   = c_q.dn_data;
    assign done_exc_valid = c_q.dn_exc;
    assign done_exc_code  = c_q.dn_code;
    assign done_exc_addr  = c_q.dn_addr;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata))); // R12

    AST_NO_MEM_ON_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(dec_aligned && dec_legal)); // R3

    AST_SC_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_valid) && mem_req_write) |-> $past(resv_hit)); // R7

    AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && c_q.dn_sc && done_rd_we) |-> !resv_valid); // R8

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !(done_rd_we && done_exc_valid)); // R9
endmodule

// File: tb/lrsc_unit_tb_top.sv
`timescale 1ns/1ps
module lrsc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid = 0, req_is_sc = 0, req_aq = 0, req_rl = 0;
    logic [63:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic        resv_clear = 0;
    logic        mem_rsp_valid = 0, mem_rsp_error = 0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        req_ready, resv_valid, mem_req_valid, mem_req_write;
    logic [63:0] mem_req_addr, mem_req_wdata, done_rd_data, done_exc_addr;
    logic [1:0]  mem_req_size;
    logic        mem_req_acquire, mem_req_release;
    logic        done_valid, done_rd_we, done_exc_valid;
    logic [3:0]  done_exc_code;

    lrsc_unit #(.XLEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_sc(req_is_sc), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_aq(req_aq), .req_rl(req_rl),
        .resv_clear(resv_clear), .resv_valid(resv_valid),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_req_wdata(mem_req_wdata), .mem_req_acquire(mem_req_acquire),
        .mem_req_release(mem_req_release), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_error(mem_rsp_error), .mem_rsp_rdata(mem_rsp_rdata),
        .done_valid(done_valid), .done_rd_we(done_rd_we),
        .done_rd_data(done_rd_data), .done_exc_valid(done_exc_valid),
        .done_exc_code(done_exc_code), .done_exc_addr(done_exc_addr)
    );

    // narrow instance for the over-wide access case
    logic        n_req_valid = 0;
    logic [31:0] n_req_addr = '0;
    logic [1:0]  n_req_size = '0;
    logic        n_ready, n_resv, n_mvalid, n_mwrite, n_macq, n_mrel;
    logic [31:0] n_maddr, n_mwdata, n_rd_data, n_exc_addr;
    logic [1:0]  n_msize;
    logic        n_done, n_we, n_exc;
    logic [3:0]  n_code;

    lrsc_unit #(.XLEN(32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .req_valid(n_req_valid), .req_ready(n_ready),
        .req_is_sc(1'b0), .req_addr(n_req_addr), .req_size(n_req_size),
        .req_wdata(32'h0), .req_aq(1'b0), .req_rl(1'b0),
        .resv_clear(1'b0), .resv_valid(n_resv),
        .mem_req_valid(n_mvalid), .mem_req_write(n_mwrite),
        .mem_req_addr(n_maddr), .mem_req_size(n_msize),
        .mem_req_wdata(n_mwdata), .mem_req_acquire(n_macq),
        .mem_req_release(n_mrel), .mem_rsp_valid(1'b0),
        .mem_rsp_error(1'b0), .mem_rsp_rdata(32'h0),
        .done_valid(n_done), .done_rd_we(n_we),
        .done_rd_data(n_rd_data), .done_exc_valid(n_exc),
        .done_exc_code(n_code), .done_exc_addr(n_exc_addr)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // captured results of one operation
    logic        c_mem, c_wr, c_acq, c_rel, c_busy_ready, c_hold;
    logic [63:0] c_addr, c_wdata;
    logic [1:0]  c_size;
    logic        d_valid, d_we, d_exc, d_next;
    logic [63:0] d_data, d_addr;
    logic [3:0]  d_code;

    task automatic do_op(input bit sc, input logic [63:0] addr, input logic [1:0] sz,
                         input logic [63:0] wd, input bit aq, input bit rl,
                         input bit err, input logic [63:0] rdata, input bit clr_at_rsp);
        @(negedge clk);
        req_valid = 1; req_is_sc = sc; req_addr = addr; req_size = sz;
        req_wdata = wd; req_aq = aq; req_rl = rl;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        c_mem = mem_req_valid; c_wr = mem_req_write; c_addr = mem_req_addr;
        c_size = mem_req_size; c_wdata = mem_req_wdata;
        c_acq = mem_req_acquire; c_rel = mem_req_release;
        c_busy_ready = req_ready; c_hold = 1'b1;
        if (c_mem) begin
            @(negedge clk);
            c_hold = mem_req_valid && (mem_req_addr == c_addr) && (mem_req_wdata == c_wdata);
            mem_rsp_valid = 1; mem_rsp_error = err; mem_rsp_rdata = rdata;
            resv_clear = clr_at_rsp;
            @(posedge clk);
            @(negedge clk);
            mem_rsp_valid = 0; mem_rsp_error = 0; resv_clear = 0;
        end
        d_valid = done_valid; d_we = done_rd_we; d_data = done_rd_data;
        d_exc = done_exc_valid; d_code = done_exc_code; d_addr = done_exc_addr;
        @(negedge clk);
        d_next = done_valid;
    endtask

    task automatic t_reset;
        chk("R1 resv_valid", resv_valid, 0);
        chk("R1 mem_req_valid", mem_req_valid, 0);
        chk("R1 done_valid", done_valid, 0);
        chk("R1 req_ready", req_ready, 1);
    endtask

    task automatic t_lr_word;
        do_op(0, 64'h1000, 2'd2, 0, 1, 0, 0, 64'h1111_2222_8000_1234, 0);
        chk("R6 read issued", {c_mem, c_wr}, 2'b10);
        chk("R6 read addr", c_addr, 64'h1000);
        chk("R6 read size", c_size, 2'd2);
        chk("R10 lr acquire", c_acq, 1);
        chk("R10 lr release", c_rel, 0);
        chk("R12 request held", c_hold, 1);
        chk("R13 not ready while busy", c_busy_ready, 0);
        chk("R13 done pulse", {d_valid, d_next}, 2'b10);
        chk("R6 rd written", {d_we, d_exc}, 2'b10);
        chk("R6 sign-extended word", d_data, 64'hFFFF_FFFF_8000_1234);
        chk("R6 reservation set", resv_valid, 1);
    endtask

    task automatic t_sc_hit;
        do_op(1, 64'h1000, 2'd2, 64'hDEAD_BEEF_CAFE_F00D, 1, 1, 0, 0, 0);
        chk("R8 write issued", {c_mem, c_wr}, 2'b11);
        chk("R8 truncated data", c_wdata, 64'h0000_0000_CAFE_F00D);
        chk("R10 sc acquire", c_acq, 1);
        chk("R10 sc release", c_rel, 1);
        chk("R8 rd success", {d_valid, d_we, d_data}, {2'b11, 64'd0});
        chk("R8 reservation dropped", resv_valid, 0);
    endtask

    task automatic t_sc_none;
        do_op(1, 64'h1000, 2'd2, 64'h55, 0, 0, 0, 0, 0);
        chk("R7 no memory write", c_mem, 0);
        chk("R7 rd fail code", {d_valid, d_we, d_data}, {2'b11, 64'd1});
    endtask

    task automatic t_lr_half_mismatch;
        do_op(0, 64'h2002, 2'd1, 0, 0, 1, 0, 64'hABCD_8001, 0);
        chk("R10 lr release aq=0", {c_acq, c_rel}, 2'b00);
        chk("R6 sign-extended half", d_data, 64'hFFFF_FFFF_FFFF_8001);
        do_op(0, 64'h2003, 2'd0, 0, 0, 0, 0, 64'h7F, 0);
        chk("R2 byte odd address aligned", c_mem, 1);
        chk("R6 positive byte", d_data, 64'h7F);
        do_op(1, 64'h2004, 2'd1, 64'h1, 0, 0, 0, 0, 0);
        chk("R7 mismatch no write", c_mem, 0);
        chk("R7 mismatch rd=1", d_data, 64'd1);
        chk("R7 reservation dropped", resv_valid, 0);
    endtask

    task automatic t_misaligned;
        do_op(0, 64'h4000, 2'd3, 0, 0, 0, 0, 64'h8877_6655_4433_2211, 0);
        chk("R2 double aligned read", c_mem, 1);
        chk("R6 double full value", d_data, 64'h8877_6655_4433_2211);
        do_op(0, 64'h3002, 2'd2, 0, 0, 0, 0, 0, 0);
        chk("R3 no memory", c_mem, 0);
        chk("R3 exception", {d_valid, d_we, d_exc, d_code}, {3'b101, 4'd4});
        chk("R3 exc addr", d_addr, 64'h3002);
        chk("R3 reservation kept", resv_valid, 1);
        do_op(0, 64'h4004, 2'd3, 0, 0, 0, 0, 0, 0);
        chk("R2 double needs bits 2:0 clear", {d_exc, d_code}, {1'b1, 4'd4});
        do_op(1, 64'h5001, 2'd1, 0, 0, 0, 0, 0, 0);
        chk("R4 store misaligned", {c_mem, d_exc, d_code}, {2'b01, 4'd6});
        chk("R4 exc addr", d_addr, 64'h5001);
        do_op(1, 64'h4000, 2'd0, 64'h1234_56AB, 0, 1, 0, 0, 0);
        chk("R3 address unchanged, sc hits", c_mem, 1);
        chk("R8 byte data", c_wdata, 64'hAB);
        chk("R10 sc aq=0 rl=1", {c_acq, c_rel}, 2'b01);
        chk("R8 rd=0", d_data, 64'd0);
    endtask

    task automatic t_errors;
        do_op(0, 64'h6000, 2'd2, 0, 0, 0, 1, 64'h5, 0);
        chk("R9 load fault", {d_valid, d_we, d_exc, d_code}, {3'b101, 4'd5});
        chk("R9 load fault addr", d_addr, 64'h6000);
        chk("R9 no reservation", resv_valid, 0);
        do_op(0, 64'h6000, 2'd2, 0, 0, 0, 0, 64'h5, 0);
        do_op(1, 64'h6000, 2'd2, 64'h9, 0, 0, 1, 0, 0);
        chk("R9 store fault", {c_mem, d_we, d_exc, d_code}, {3'b101, 4'd7});
        chk("R9 store drops reservation", resv_valid, 0);
    endtask

    task automatic t_clear;
        do_op(0, 64'h7000, 2'd2, 0, 0, 0, 0, 64'h1, 0);
        chk("R6 reservation before clear", resv_valid, 1);
        @(negedge clk); resv_clear = 1;
        @(negedge clk); resv_clear = 0;
        chk("R11 clear invalidates", resv_valid, 0);
        do_op(1, 64'h7000, 2'd2, 64'h2, 0, 0, 0, 0, 0);
        chk("R11 sc after clear fails", {c_mem, d_data}, {1'b0, 64'd1});
        do_op(0, 64'h7008, 2'd2, 0, 0, 0, 0, 64'h3, 1);
        chk("R11 clear beats load", resv_valid, 0);
        do_op(1, 64'h7008, 2'd2, 64'h2, 0, 0, 0, 0, 0);
        chk("R11 sc after same-cycle clear", {c_mem, d_data}, {1'b0, 64'd1});
    endtask

    task automatic t_narrow;
        @(negedge clk);
        n_req_valid = 1; n_req_addr = 32'h8000; n_req_size = 2'd3;
        @(posedge clk);
        @(negedge clk);
        n_req_valid = 0;
        chk("R5 no memory on wide access", n_mvalid, 0);
        chk("R5 illegal code", {n_done, n_we, n_exc, n_code}, {3'b101, 4'd2});
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_lr_word();
        t_sc_hit();
        t_sc_none();
        t_lr_half_mismatch();
        t_misaligned();
        t_errors();
        t_clear();
        t_narrow();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule